// File: doc/BRIEF.md
# Effective Address and Branch-Target Generator

This unit computes memory addresses and branch targets for a 32-bit RISC core whose instructions are all 16 bits long. Each request carries a mode code, an access size, a base register value, the current program counter, a displacement field, a condition bit and a loop counter value. The unit produces one 32-bit address per request. For the two branch modes it also produces a taken decision. For the loop mode it also produces the decremented counter as a write-back value. Every address that depends on the PC is measured from the next sequential instruction, PC+2.

The arithmetic is purely combinational. The results are held in one output register stage, and a valid strobe follows a valid request by one clock. When no request is presented, the registered results keep their last values. All sums wrap modulo 2^32. Each mode reads only the low bits of the displacement field that belong to it. The mode codes are: 0 base plus scaled displacement, 1 PC-relative literal, 2 conditional branch, 3 loop branch.

Top module: `ea_branch_gen`

## Requirements
- R1: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 otherwise. A synchronous reset clears `out_valid`, `addr`, `taken` and `cnt_next` to 0.
- R2: In mode 0, `addr` = `base` + `field[3:0]` × scale. The scale is 1 for size code 0 (byte), 2 for size code 1 (halfword), and 4 for size codes 2 (word) and 3.
- R3: In mode 1, `addr` = (`pc` + 2 + `field[7:0]` × 4) with bits [1:0] forced to 0.
- R4: In mode 2, `addr` = `pc` + 2 + 2 × the two's-complement value of `field[10:0]`.
- R5: In mode 2, `taken` equals `cond`.
- R6: In mode 3, `addr` = `pc` + 2 − 2 × `field[3:0]`.
- R7: In mode 3, `cnt_next` = `loop_cnt` − 1, and `taken` is 1 exactly when that decremented value is nonzero.
- R8: In modes 0 and 1, `taken` and `cnt_next` are 0, whatever `cond` and `loop_cnt` hold.
- R9: While `in_valid` is 0, `addr`, `taken` and `cnt_next` keep the values from the last valid request.
- R10: All address and counter arithmetic wraps modulo 2^32.
- R11: Field bits that a mode does not use have no effect on its results. These are `field[10:4]` in modes 0 and 3, and `field[10:8]` in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Mode code (0 base+disp, 1 literal, 2 cond branch, 3 loop) |
| size | input | 2 | Access size code for mode 0 |
| base | input | 32 | Base register value |
| pc | input | 32 | Address of the current instruction |
| field | input | 11 | Immediate or displacement field |
| cond | input | 1 | Condition-code bit |
| loop_cnt | input | 32 | Loop counter value before decrement |
| out_valid | output | 1 | Registered result valid |
| addr | output | 32 | Registered address or target |
| taken | output | 1 | Registered branch decision |
| cnt_next | output | 32 | Registered decremented loop counter |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 2-byte instructions, and field widths of 4, 8 and 11 bits. These defaults bring the real corner cases within reach. The most negative and most positive 11-bit branch displacements can be applied, and so can the largest literal offset. A PC or base near 2^32 exercises the wrap. A loop counter of 0, 1 or 2 covers each side of the taken decision. Directed cases cover every size code and ignored field bits. A seeded pseudo-random stream then mixes modes, idle cycles and back-to-back requests.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MODE_LDST  = 2'd0,
    MODE_LIT   = 2'd1,
    MODE_BCOND = 2'd2,
    MODE_LOOP  = 2'd3
  } ea_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } ea_size_e;
endpackage

// File: rtl/agu_ldst.sv
module agu_ldst #(
  parameter int XLEN = 32,
  parameter int DW   = 4
) (
  input  logic [XLEN-1:0] base,
  input  logic [DW-1:0]   disp,
  input  logic [1:0]      size,
  output logic [XLEN-1:0] ea
);
  import ea_pkg::*;

  // Scale an unsigned displacement by the access width in bytes.
  function automatic logic [XLEN-1:0] scaled_disp(input logic [DW-1:0] d,
                                                  input logic [1:0] sz);
    logic [XLEN-1:0] z;
    z = {{(XLEN-DW){1'b0}}, d};
    case (ea_size_e'(sz))
      SZ_BYTE: return z;
      SZ_HALF: return z << 1;
      default: return z << 2;
    endcase
  endfunction

  assign ea = base + scaled_disp(disp, size);
endmodule

// File: rtl/agu_pcrel.sv
module agu_pcrel #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 2,
  parameter int LIT_W      = 8,
  parameter int BR_W       = 11,
  parameter int LOOP_W     = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [BR_W-1:0] field,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] lit_addr,
  output logic [XLEN-1:0] br_addr,
  output logic [XLEN-1:0] loop_addr
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] WORD_MSK = {{(XLEN-2){1'b1}}, 2'b00};

  function automatic logic [XLEN-1:0] lit_offset(input logic [LIT_W-1:0] f);
    return {{(XLEN-LIT_W){1'b0}}, f} << 2;
  endfunction

  function automatic logic [XLEN-1:0] br_offset(input logic [BR_W-1:0] f);
    return {{(XLEN-BR_W){f[BR_W-1]}}, f} << 1;
  endfunction

  function automatic logic [XLEN-1:0] loop_offset(input logic [LOOP_W-1:0] f);
    return {{(XLEN-LOOP_W){1'b0}}, f} << 1;
  endfunction

  logic [XLEN-1:0] lit_sum;

  assign seq_pc    = pc + STEP;
  assign lit_sum   = seq_pc + lit_offset(field[LIT_W-1:0]);
  assign lit_addr  = lit_sum & WORD_MSK;
  assign br_addr   = seq_pc + br_offset(field);
  assign loop_addr = seq_pc - loop_offset(field[LOOP_W-1:0]);
endmodule

// File: rtl/agu_loopctl.sv
module agu_loopctl #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cnt,
  output logic [XLEN-1:0] cnt_dec,
  output logic            loop_take
);
  function automatic logic [XLEN-1:0] dec1(input logic [XLEN-1:0] v);
    return v - XLEN'(1);
  endfunction

  assign cnt_dec   = dec1(cnt);
  assign loop_take = |cnt_dec;
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] addr_d,
  input  logic            taken_d,
  input  logic [XLEN-1:0] cnt_d,
  output logic            out_valid,
  output logic [XLEN-1:0] addr_q,
  output logic            taken_q,
  output logic [XLEN-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr_q    <= '0;
      taken_q   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr_q  <= addr_d;
        taken_q <= taken_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(addr_q) && $stable(taken_q) && $stable(cnt_q)));
endmodule

// File: rtl/ea_branch_gen.sv
module ea_branch_gen #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 2,
  parameter int LDST_W     = 4,
  parameter int LIT_W      = 8,
  parameter int BR_W       = 11,
  parameter int LOOP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   pc,
  input  logic [BR_W-1:0]   field,
  input  logic              cond,
  input  logic [XLEN-1:0]   loop_cnt,
  output logic              out_valid,
  output logic [XLEN-1:0]   addr,
  output logic              taken,
  output logic [XLEN-1:0]   cnt_next
);
  import ea_pkg::*;

  // Event wires shared by the datapath and the assertions.
  logic [XLEN-1:0] ldst_ea;
  logic [XLEN-1:0] seq_pc, lit_ea, br_ea, loop_ea;
  logic [XLEN-1:0] cnt_dec;
  logic            loop_take;
  logic            is_branch;
  logic [XLEN-1:0] addr_d, cnt_d;
  logic            taken_d;

  agu_ldst #(.XLEN(XLEN), .DW(LDST_W)) u_ldst (
    .base (base),
    .disp (field[LDST_W-1:0]),
    .size (size),
    .ea   (ldst_ea)
  );

  agu_pcrel #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .LIT_W(LIT_W),
              .BR_W(BR_W), .LOOP_W(LOOP_W)) u_pcrel (
    .pc        (pc),
    .field     (field),
    .seq_pc    (seq_pc),
    .lit_addr  (lit_ea),
    .br_addr   (br_ea),
    .loop_addr (loop_ea)
  );

  agu_loopctl #(.XLEN(XLEN)) u_loop (
    .cnt       (loop_cnt),
    .cnt_dec   (cnt_dec),
    .loop_take (loop_take)
  );

  assign is_branch = (mode == MODE_BCOND) || (mode == MODE_LOOP);

  always_comb begin
    addr_d  = ldst_ea;
    taken_d = 1'b0;
    cnt_d   = '0;
    case (ea_mode_e'(mode))
      MODE_LDST:  addr_d = ldst_ea;
      MODE_LIT:   addr_d = lit_ea;
      MODE_BCOND: begin
        addr_d  = br_ea;
        taken_d = cond;
      end
      MODE_LOOP: begin
        addr_d  = loop_ea;
        taken_d = loop_take;
        cnt_d   = cnt_dec;
      end
      default: addr_d = ldst_ea;
    endcase
  end

  agu_outreg #(.XLEN(XLEN)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .addr_d    (addr_d),
    .taken_d   (taken_d),
    .cnt_d     (cnt_d),
    .out_valid (out_valid),
    .addr_q    (addr),
    .taken_q   (taken),
    .cnt_q     (cnt_next)
  );

  // R3
  lit_align_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_LIT) |=> (addr[1:0] == 2'b00));
  // R5
  bcond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_BCOND) |=> (taken == $past(cond)));
  // R7
  loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_LOOP) |=> (cnt_next == $past(loop_cnt) - XLEN'(1)));
  // R8
  nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_branch) |=> (!taken && cnt_next == '0));
  // R2
  word_align_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_LDST && size[1]) |=> (addr[1:0] == $past(base[1:0])));
endmodule

// File: tb/ea_branch_gen_bench.sv
module ea_branch_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [31:0] base = '0;
  logic [31:0] pc = '0;
  logic [10:0] field = '0;
  logic        cond = 1'b0;
  logic [31:0] loop_cnt = '0;
  logic        out_valid;
  logic [31:0] addr;
  logic        taken;
  logic [31:0] cnt_next;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // expectation of the registered outputs after the next edge
  bit          e_valid = 0;
  logic [31:0] e_addr = '0;
  bit          e_taken = 0;
  logic [31:0] e_cnt = '0;
  string       e_tag = "R1";
  bit          armed = 0;

  always #2 clk = ~clk;

  ea_branch_gen u_ea_branch_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size(size),
    .base(base), .pc(pc), .field(field), .cond(cond), .loop_cnt(loop_cnt),
    .out_valid(out_valid), .addr(addr), .taken(taken), .cnt_next(cnt_next)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: wide signed integers, truncated at the end
  task automatic model(input bit v, input int md, input int sz, input longint b,
                       input longint p, input int f, input bit c, input longint lc,
                       input string tag);
    longint a;
    longint s;
    e_valid = v;
    if (!v) begin
      e_tag = "R9";
      return;
    end
    e_tag = tag;
    e_taken = 0;
    e_cnt = 0;
    case (md)
      0: begin
        s = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        a = b + (f % 16) * s;
      end
      1: begin
        a = p + 2 + (f % 256) * 4;
        a = a - (a % 4);
      end
      2: begin
        s = (f >= 1024) ? f - 2048 : f;
        a = p + 2 + 2 * s;
        e_taken = c;
      end
      default: begin
        a = p + 2 - 2 * (f % 16);
        s = lc - 1;
        e_cnt = s[31:0];
        e_taken = (e_cnt != 0);
      end
    endcase
    e_addr = a[31:0];
  endtask

  task automatic step(input bit v, input int md, input int sz, input logic [31:0] b,
                      input logic [31:0] p, input int f, input bit c,
                      input logic [31:0] lc, input string tag);
    @(negedge clk);
    if (armed) begin
      chk((e_valid ? "R1" : "R1"), "out_valid", {31'b0, out_valid}, {31'b0, e_valid});
      chk(e_tag, "addr", addr, e_addr);
      chk(e_tag, "taken", {31'b0, taken}, {31'b0, e_taken});
      chk(e_tag, "cnt_next", cnt_next, e_cnt);
    end
    in_valid = v; mode = md[1:0]; size = sz[1:0]; base = b; pc = p;
    field = f[10:0]; cond = c; loop_cnt = lc;
    model(v, md, sz, {32'b0, b}, {32'b0, p}, f, c, {32'b0, lc}, tag);
    armed = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1", "reset addr", addr, 32'h0);
    chk("R1", "reset taken", {31'b0, taken}, 32'h0);
    chk("R1", "reset cnt_next", cnt_next, 32'h0);
    rst = 1'b0;

    // R2 every size code
    step(1, 0, 2, 32'h0000_0100, 32'h0, 4,  1, 32'h5, "R2");
    step(1, 0, 1, 32'h0000_0100, 32'h0, 15, 0, 32'h0, "R2");
    step(1, 0, 0, 32'h0000_0103, 32'h0, 7,  0, 32'h0, "R2");
    step(1, 0, 3, 32'h0000_0200, 32'h0, 15, 0, 32'h0, "R2");
    // R11 upper field bits ignored in mode 0
    step(1, 0, 2, 32'h0000_0100, 32'h0, 11'h7F4, 0, 32'h0, "R11");
    // R10 base wrap
    step(1, 0, 2, 32'hFFFF_FFFC, 32'h0, 2, 0, 32'h0, "R10");
    // R3 literal
    step(1, 1, 0, 32'h0, 32'h0000_1000, 25,  1, 32'h9, "R3");
    step(1, 1, 0, 32'h0, 32'h0000_1002, 255, 0, 32'h0, "R3");
    step(1, 1, 0, 32'h0, 32'h0000_1002, 11'h703, 0, 32'h0, "R11");
    // R9 idle hold
    step(0, 2, 0, 32'h0, 32'h1234_5678, 99, 1, 32'h0, "R9");
    step(0, 3, 0, 32'h0, 32'h0, 3, 1, 32'h7, "R9");
    // R4 / R5 conditional branch
    step(1, 2, 0, 32'h0, 32'h0000_2000, 11'h7F8, 1, 32'h0, "R4");
    step(1, 2, 0, 32'h0, 32'h0000_2000, 11'h7F8, 0, 32'h0, "R5");
    step(1, 2, 0, 32'h0, 32'h0000_2000, 11'h400, 1, 32'h0, "R4");
    step(1, 2, 0, 32'h0, 32'h0000_2000, 11'h3FF, 0, 32'h0, "R4");
    step(1, 2, 0, 32'h0, 32'hFFFF_FFFE, 0, 1, 32'h0, "R10");
    // R6 / R7 loop
    step(1, 3, 0, 32'h0, 32'h0000_3000, 4, 0, 32'h2, "R7");
    step(1, 3, 0, 32'h0, 32'h0000_3000, 15, 1, 32'h1, "R7");
    step(1, 3, 0, 32'h0, 32'h0000_3000, 0, 0, 32'h0, "R10");
    step(1, 3, 0, 32'h0, 32'h0000_0004, 15, 0, 32'h10, "R6");
    step(1, 3, 0, 32'h0, 32'h0000_3000, 11'h7F4, 0, 32'h10, "R11");
    // R8 cond and counter ignored in modes 0/1
    step(1, 0, 2, 32'h40, 32'h0, 1, 1, 32'hFFFF, "R8");
    step(1, 1, 0, 32'h0, 32'h40, 1, 1, 32'h1, "R8");

    // pseudo-random mix
    x = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r1, r2, r3;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); r1 = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); r2 = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); r3 = x;
      step(r1[31:29] != 3'b000, int'(r1[1:0]), int'(r1[3:2]), r2, r3,
           int'(r1[14:4]), r1[15], {28'b0, r1[19:16]} ^ {r3[31:4], 4'b0},
           (r1[1:0] == 2'd0) ? "R2" : (r1[1:0] == 2'd1) ? "R3" :
           (r1[1:0] == 2'd2) ? "R4" : "R6");
    end
    step(0, 0, 0, 32'h0, 32'h0, 0, 0, 32'h0, "R9");
    step(0, 0, 0, 32'h0, 32'h0, 0, 0, 32'h0, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule